// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Handling

This block turns an asynchronous serial line into characters. It samples the line on a 16x oversampling enable, which the baud generator outside the block supplies. A start bit counts only if the line is still low at the middle of that bit. The block then takes each data bit, the optional parity bit and the first stop bit at the middle of the bit. Each finished character is written, together with its own parity, framing and break flags, into a small first-in first-out buffer of four entries. The host empties the buffer one entry per read strobe.

When the line is held low for a whole character, the block records a single break entry. It signals the start of the break and, later, the return of the line to high as two separate one-cycle events. A break that starts while a character is arriving leaves that character in the buffer with a framing error, and a break entry follows it. If a character arrives while the buffer is full, the character is lost and a sticky overrun flag is set.

For multidrop links there is a wake-up filter. While it is enabled and the receiver is asleep, only characters whose address-flag bit is high reach the buffer. The address-flag bit sits where the parity bit would be.

Top module: `uart_rx_brk`

## Requirements
- R1: With `cfg_len` = 0/1/2/3 the character has 5/6/7/8 data bits, taken least significant first. Stored data bits above the character length read as 0. A clean character has all three flags clear.
- R2: `cfg_par` sets the parity mode: 0 none, 1 even (data plus parity bit hold an even number of ones), 2 odd, 3 forced (the parity bit must equal `cfg_force_bit`). A mismatch sets `rd_perr` on that entry and the data is still stored.
- R3: A character whose first stop sample is low and which is not a break is stored with `rd_ferr` = 1. Only the first stop bit is checked.
- R4: If the line has gone high again by the mid-bit sample, 8 ticks after the falling edge, the start is false. The receiver returns to idle without storing anything, and the next valid character is received normally.
- R5: The buffer holds up to four entries and returns them in arrival order. `rx_level` gives the number of stored entries and `rx_valid` is high when that number is not zero.
- R6: A character that arrives while the buffer is full is dropped and the four stored entries stay unchanged. It sets `overrun`, which stays high until `ovr_clr`.
- R7: A character whose data, parity and stop samples are all low is a break. It is stored once as data 0 with `rd_brk` = 1 and the other two flags clear. Nothing more is stored until the line returns high.
- R8: `brk_start` pulses for one cycle when the break is recognised. `brk_end` pulses for one cycle when the line is next seen high.
- R9: A break that begins partway through a character leaves that truncated character in the buffer with a framing error, and a break entry follows it.
- R10: While `cfg_wake_en` = 1 the receiver always expects an address-flag bit where the parity bit would be, and it reports no parity errors. While asleep it discards characters whose flag bit is 0. The first character with the flag bit at 1 is stored and sets `rx_awake`. After that every character is stored until `wake_clr` clears `rx_awake`.
- R11: After reset the buffer is empty, and `overrun`, `rx_awake`, `brk_start` and `brk_end` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length code (5 + value bits) |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 forced |
| cfg_force_bit | input | 1 | Parity level expected in forced mode |
| cfg_wake_en | input | 1 | Multidrop wake-up filter enable |
| wake_clr | input | 1 | Puts the receiver back to sleep |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_en | input | 1 | Removes the head entry |
| rx_valid | output | 1 | Buffer not empty |
| rx_level | output | 3 | Number of stored entries |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry is a break |
| overrun | output | 1 | Sticky overrun flag |
| rx_awake | output | 1 | Wake-up filter has seen an address character |
| brk_start | output | 1 | One-cycle pulse when a break is recognised |
| brk_end | output | 1 | One-cycle pulse when the line returns high after a break |

## Verification
The receiver is driven with well-formed characters of every length and every parity mode. These separate bit ordering, length masking and the parity sense. Frames with a low stop bit, and frames with a wrong parity bit, show that each error raises its own flag. A short low glitch tests start rejection. Long lows, both from idle and from partway through a character, tell a framing error apart from a break and check that the start and end events pulse exactly once. A burst of five characters that nobody reads, and a wake-up sequence of address and data characters with the flag bit at 0 and at 1, check overrun and the multidrop filter.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_FORCE = 2'd3
  } par_mode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_BRKW
  } rx_state_t;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
`timescale 1ns/1ps
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rx,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic      cfg_force_bit,
  input  logic      wake_en,
  input  logic      wake_clr,
  output logic      push_o,
  output rx_entry_t entry_o,
  output logic      brk_start_o,
  output logic      brk_end_o,
  output logic      awake_o
);
  localparam int TW   = $clog2(OSR);
  localparam int BW   = $clog2(DATA_W);
  localparam int MID  = OSR/2 - 1;
  localparam int LAST = OSR - 1;

  rx_state_t         state;
  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bcnt;
  logic [DATA_W-1:0] shreg;
  logic              all_low;
  logic              par_s;

  logic [BW-1:0] last_bit;
  logic          par_slot;
  logic          par_ok;
  logic          is_brk;
  logic          perr_c;
  logic          ferr_c;
  logic          accept;

  assign last_bit = BW'(cfg_len) + BW'(DATA_W - 4);
  assign par_slot = wake_en || (cfg_par != PAR_NONE);

  always_comb begin
    case (par_mode_t'(cfg_par))
      PAR_EVEN:  par_ok = ~(^shreg ^ par_s);
      PAR_ODD:   par_ok =  (^shreg ^ par_s);
      PAR_FORCE: par_ok =  (par_s == cfg_force_bit);
      default:   par_ok = 1'b1;
    endcase
  end

  // Evaluated while the stop bit is being sampled.
  assign is_brk = all_low & ~rx;
  assign ferr_c = ~rx & ~is_brk;
  assign perr_c = ~wake_en & ~par_ok & ~is_brk;
  assign accept = is_brk | ~wake_en | awake_o | par_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      tcnt        <= '0;
      bcnt        <= '0;
      shreg       <= '0;
      all_low     <= 1'b0;
      par_s       <= 1'b0;
      push_o      <= 1'b0;
      entry_o     <= '0;
      brk_start_o <= 1'b0;
      brk_end_o   <= 1'b0;
      awake_o     <= 1'b0;
    end else begin
      push_o      <= 1'b0;
      brk_start_o <= 1'b0;
      brk_end_o   <= 1'b0;
      if (wake_clr) awake_o <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            tcnt <= '0;
            if (!rx) state <= S_START;
          end
          S_START: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TW'(MID)) begin
              tcnt <= '0;
              if (!rx) begin
                state   <= S_DATA;
                bcnt    <= '0;
                shreg   <= '0;
                par_s   <= 1'b0;
                all_low <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_DATA: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TW'(LAST)) begin
              shreg[bcnt] <= rx;
              all_low     <= all_low & ~rx;
              if (bcnt == last_bit) state <= par_slot ? S_PAR : S_STOP;
              else                  bcnt  <= bcnt + 1'b1;
            end
          end
          S_PAR: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TW'(LAST)) begin
              par_s   <= rx;
              all_low <= all_low & ~rx;
              state   <= S_STOP;
            end
          end
          S_STOP: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TW'(LAST)) begin
              push_o        <= accept;
              entry_o.brk   <= is_brk;
              entry_o.ferr  <= ferr_c;
              entry_o.perr  <= perr_c;
              entry_o.data  <= is_brk ? '0 : shreg;
              brk_start_o   <= is_brk;
              if (wake_en && !awake_o && par_s && !is_brk) awake_o <= 1'b1;
              state <= is_brk ? S_BRKW : S_IDLE;
            end
          end
          S_BRKW: begin
            tcnt <= '0;
            if (rx) begin
              brk_end_o <= 1'b1;
              state     <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_brk_entry_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (push_o && entry_o.brk) |-> (entry_o.data == '0 && !entry_o.ferr && !entry_o.perr));

  assert_no_store_in_break_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_BRKW) |-> !push_o);

  assert_brk_end_after_wait_R8: assert property (@(posedge clk) disable iff (rst)
    brk_end_o |-> ($past(state) == S_BRKW));

  assert_false_start_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_START && tick && tcnt == TW'(MID) && rx) |=> (state == S_IDLE));

  assert_wake_filter_R10: assert property (@(posedge clk) disable iff (rst)
    (push_o && wake_en && !entry_o.brk) |-> ($past(awake_o) || par_s));
endmodule

// File: rtl/rx_fifo.sv
`timescale 1ns/1ps
module rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 11
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      if (push_ok && !pop_ok)      level <= level + 1'b1;
      else if (pop_ok && !push_ok) level <= level - 1'b1;
    end
  end

  assign dout = mem[rd_ptr];

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  assert_full_keeps_level_R6: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (level == $past(level)));

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/uart_rx_brk.sv
`timescale 1ns/1ps
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int OSR   = 16,
  parameter int SYNC  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_16x,
  input  logic                       rx_in,
  input  logic [1:0]                 cfg_len,
  input  logic [1:0]                 cfg_par,
  input  logic                       cfg_force_bit,
  input  logic                       cfg_wake_en,
  input  logic                       wake_clr,
  input  logic                       ovr_clr,
  input  logic                       rd_en,
  output logic                       rx_valid,
  output logic [$clog2(DEPTH+1)-1:0] rx_level,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_perr,
  output logic                       rd_ferr,
  output logic                       rd_brk,
  output logic                       overrun,
  output logic                       rx_awake,
  output logic                       brk_start,
  output logic                       brk_end
);
  localparam int EW = $bits(rx_entry_t);

  logic      rx_s;
  logic      frm_push;
  rx_entry_t frm_entry;
  rx_entry_t head;
  logic      f_full, f_empty;

  rx_sync #(.STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_in),
    .q   (rx_s)
  );

  rx_frame #(.OSR(OSR)) u_frame (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick_16x),
    .rx            (rx_s),
    .cfg_len       (cfg_len),
    .cfg_par       (cfg_par),
    .cfg_force_bit (cfg_force_bit),
    .wake_en       (cfg_wake_en),
    .wake_clr      (wake_clr),
    .push_o        (frm_push),
    .entry_o       (frm_entry),
    .brk_start_o   (brk_start),
    .brk_end_o     (brk_end),
    .awake_o       (rx_awake)
  );

  rx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (frm_push),
    .din   (EW'(frm_entry)),
    .pop   (rd_en),
    .dout  (head),
    .level (rx_level),
    .full  (f_full),
    .empty (f_empty)
  );

  always_ff @(posedge clk) begin
    if (rst)                            overrun <= 1'b0;
    else if (frm_push && f_full && !rd_en) overrun <= 1'b1;
    else if (ovr_clr)                   overrun <= 1'b0;
  end

  assign rx_valid = !f_empty;
  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;
  assign rd_brk   = head.brk;

  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);

  assert_ovr_on_full_push_R6: assert property (@(posedge clk) disable iff (rst)
    (frm_push && f_full && !rd_en) |=> overrun);
endmodule

// File: tb/tb_uart_rx_brk.sv
`timescale 1ns/1ps
module tb_uart_rx_brk;
  localparam int BIT = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_16x;
  logic       rx_in = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_par = 2'd0;
  logic       cfg_force_bit = 1'b0;
  logic       cfg_wake_en = 1'b0;
  logic       wake_clr = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       rd_en = 1'b0;
  logic       rx_valid;
  logic [2:0] rx_level;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk;
  logic       overrun, rx_awake, brk_start, brk_end;

  int checks = 0;
  int errors = 0;
  int n_bstart = 0;
  int n_bend = 0;
  logic [1:0] tdiv = 2'd0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    if (brk_start) n_bstart <= n_bstart + 1;
    if (brk_end)   n_bend   <= n_bend + 1;
  end
  assign tick_16x = (tdiv == 2'd3);

  uart_rx_brk dut (
    .clk(clk), .rst(rst), .tick_16x(tick_16x), .rx_in(rx_in),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_force_bit(cfg_force_bit),
    .cfg_wake_en(cfg_wake_en), .wake_clr(wake_clr), .ovr_clr(ovr_clr),
    .rd_en(rd_en), .rx_valid(rx_valid), .rx_level(rx_level),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .overrun(overrun), .rx_awake(rx_awake), .brk_start(brk_start), .brk_end(brk_end)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic v);
    rx_in = v;
    cyc(BIT);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nbits, input bit haspar,
                            input logic pbit, input logic stopv);
    send_bit(1'b0);
    for (int i = 0; i < nbits; i++) send_bit(d[i]);
    if (haspar) send_bit(pbit);
    send_bit(stopv);
    rx_in = 1'b1;
    cyc(2*BIT);
  endtask

  function automatic logic even_bit(input logic [7:0] d, input int nbits);
    logic p = 1'b0;
    for (int i = 0; i < nbits; i++) p ^= d[i];
    return p;
  endfunction

  task automatic pop_check(input string req, input int d, input int pe, input int fe, input int bk);
    chk({req, " valid"}, int'(rx_valid), 1);
    chk({req, " data"}, int'(rd_data), d);
    chk({req, " perr"}, int'(rd_perr), pe);
    chk({req, " ferr"}, int'(rd_ferr), fe);
    chk({req, " brk"}, int'(rd_brk), bk);
    rd_en = 1'b1;
    cyc(1);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 valid", int'(rx_valid), 0);
    chk("R11 level", int'(rx_level), 0);
    chk("R11 overrun", int'(overrun), 0);
    chk("R11 awake", int'(rx_awake), 0);
    chk("R11 brk events", n_bstart + n_bend, 0);
  endtask

  task automatic t_lengths();
    cfg_par = 2'd0;
    cfg_len = 2'd3;
    send_frame(8'hA5, 8, 0, 1'b0, 1'b1);
    send_frame(8'h3C, 8, 0, 1'b0, 1'b1);
    chk("R1 level", int'(rx_level), 2);
    pop_check("R1 8bit a", 8'hA5, 0, 0, 0);
    pop_check("R1 8bit b", 8'h3C, 0, 0, 0);
    cfg_len = 2'd0;
    send_frame(8'hFF, 5, 0, 1'b0, 1'b1);
    pop_check("R1 5bit mask", 8'h1F, 0, 0, 0);
  endtask

  task automatic t_parity();
    cfg_len = 2'd1; cfg_par = 2'd1;
    send_frame(8'h2B, 6, 1, even_bit(8'h2B, 6), 1'b1);
    send_frame(8'h2B, 6, 1, ~even_bit(8'h2B, 6), 1'b1);
    pop_check("R2 even ok", 8'h2B, 0, 0, 0);
    pop_check("R2 even bad", 8'h2B, 1, 0, 0);
    cfg_len = 2'd2; cfg_par = 2'd2;
    send_frame(8'h41, 7, 1, ~even_bit(8'h41, 7), 1'b1);
    send_frame(8'h41, 7, 1, even_bit(8'h41, 7), 1'b1);
    pop_check("R2 odd ok", 8'h41, 0, 0, 0);
    pop_check("R2 odd bad", 8'h41, 1, 0, 0);
    cfg_len = 2'd3; cfg_par = 2'd3; cfg_force_bit = 1'b1;
    send_frame(8'h96, 8, 1, 1'b1, 1'b1);
    send_frame(8'h96, 8, 1, 1'b0, 1'b1);
    pop_check("R2 force ok", 8'h96, 0, 0, 0);
    pop_check("R2 force bad", 8'h96, 1, 0, 0);
    cfg_par = 2'd0; cfg_force_bit = 1'b0;
  endtask

  task automatic t_framing();
    send_frame(8'h81, 8, 0, 1'b0, 1'b0);
    pop_check("R3 frame err", 8'h81, 0, 1, 0);
    chk("R3 no break event", n_bstart, 0);
  endtask

  task automatic t_false_start();
    rx_in = 1'b0;
    cyc(12);
    rx_in = 1'b1;
    cyc(3*BIT);
    chk("R4 glitch not stored", int'(rx_level), 0);
    send_frame(8'h5A, 8, 0, 1'b0, 1'b1);
    pop_check("R4 recovers", 8'h5A, 0, 0, 0);
  endtask

  task automatic t_overrun();
    for (int i = 1; i <= 5; i++) send_frame(8'(i), 8, 0, 1'b0, 1'b1);
    chk("R5 level full", int'(rx_level), 4);
    chk("R6 overrun set", int'(overrun), 1);
    for (int i = 1; i <= 4; i++) pop_check("R5 R6 order", i, 0, 0, 0);
    chk("R6 fifth dropped", int'(rx_valid), 0);
    chk("R6 still sticky", int'(overrun), 1);
    ovr_clr = 1'b1; cyc(1); ovr_clr = 1'b0;
    chk("R6 cleared", int'(overrun), 0);
  endtask

  task automatic t_break();
    int s0 = n_bstart;
    int e0 = n_bend;
    rx_in = 1'b0;
    cyc(20*BIT);
    chk("R7 single entry", int'(rx_level), 1);
    chk("R8 start pulse", n_bstart - s0, 1);
    chk("R8 no end while low", n_bend - e0, 0);
    rx_in = 1'b1;
    cyc(2*BIT);
    chk("R8 end pulse", n_bend - e0, 1);
    chk("R7 level after", int'(rx_level), 1);
    pop_check("R7 break entry", 0, 0, 0, 1);
  endtask

  task automatic t_mid_break();
    int s0 = n_bstart;
    int e0 = n_bend;
    send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    rx_in = 1'b0;
    cyc(24*BIT);
    rx_in = 1'b1;
    cyc(2*BIT);
    chk("R9 two entries", int'(rx_level), 2);
    pop_check("R9 truncated", 8'h07, 0, 1, 0);
    pop_check("R9 break follows", 0, 0, 0, 1);
    chk("R9 start event", n_bstart - s0, 1);
    chk("R9 end event", n_bend - e0, 1);
  endtask

  task automatic t_wake();
    cfg_wake_en = 1'b1; cfg_par = 2'd1; cfg_len = 2'd3;
    send_frame(8'h11, 8, 1, 1'b0, 1'b1);
    chk("R10 asleep discards", int'(rx_level), 0);
    send_frame(8'h42, 8, 1, 1'b1, 1'b1);
    chk("R10 awake", int'(rx_awake), 1);
    send_frame(8'h54, 8, 1, 1'b0, 1'b1);
    chk("R10 level", int'(rx_level), 2);
    pop_check("R10 address", 8'h42, 0, 0, 0);
    pop_check("R10 data no perr", 8'h54, 0, 0, 0);
    wake_clr = 1'b1; cyc(1); wake_clr = 1'b0;
    chk("R10 asleep again", int'(rx_awake), 0);
    send_frame(8'h66, 8, 1, 1'b0, 1'b1);
    chk("R10 discards after clear", int'(rx_level), 0);
    cfg_wake_en = 1'b0; cfg_par = 2'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(4*BIT);
    t_reset();
    t_lengths();
    t_parity();
    t_framing();
    t_false_start();
    t_overrun();
    t_break();
    t_mid_break();
    t_wake();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule